// File: doc/BRIEF.md
# Dual-Exposure Rolling Shutter Sequencer

This block paces an electronic rolling shutter over a programmable window of sensor rows. Every row is reset and, a fixed number of row periods later, read. That number of row periods is the integration time, and it is the same for every row of a frame. Each row period is announced by a one-cycle row tick. A frame is launched by a frame-start pulse, and it runs until the last row of the window has been read.

In linear mode, the only mode after reset, one reset/read pointer pair walks the window. In HDR mode a second, shorter exposure runs in the same rolling readout through a second pointer pair. The second exposure is set either as a power-of-two fraction of the first or as an explicit row count. Both exposures of a row are read in the same row period, with the long exposure first, so a downstream line-interleaved formatter sees T1 and T2 lines alternate. Each strobe carries a row address and an exposure tag. An output selector can pass only T1 reads or only T2 reads.

All configuration is captured at frame start. A change made while a frame is running therefore never mixes two integration times in one frame. Row ticks must be at least three clock cycles apart.

Top module: `dual_exposure_shutter_seq`

## Requirements
- R1: After reset, frameBusy, rstValid and rdValid are low, and rstRow, rdRow, rstTag and rdTag are zero.
- R2: A frameStart pulse seen while frameBusy is low begins a frame and captures all configuration inputs. frameStart pulses and configuration changes seen while frameBusy is high have no effect on the running frame.
- R3: Let N = rowLast-rowFirst+1 (taken as 1 when rowLast < rowFirst) and I1 = max(1, t1Rows). Number the row ticks of a frame as slots s = 0, 1, 2 and so on. In slot s a T1 reset of row rowFirst+s is issued when s < N. The frame lasts N+I1 slots, and frameBusy falls together with the late strobes of the last slot.
- R4: In slot s a T1 read of row rowFirst+s-I1 is issued when 0 <= s-I1 < N, so each row is read exactly I1 slots after its T1 reset.
- R5: In HDR mode (hdrEn=1), with T2 integration I2 and D = I1-I2, a T2 reset of row rowFirst+s-D is issued in slot s when 0 <= s-D < N. The T2 read of a row is issued in the same slot as its T1 read.
- R6: In ratio mode (t2ByRows=0), ratioSel values 0, 1, 2 and 3 select ratios of 4x, 8x, 16x and 32x, and I2 = max(1, I1 >> (ratioSel+2)).
- R7: In row-count mode (t2ByRows=1), I2 = t2Rows clamped to the range 1..I1.
- R8: The row tick is sampled at clock edge k. T1 strobes are high for the single cycle after edge k+1, and T2 strobes for the single cycle after edge k+2. No strobe is high in any other cycle.
- R9: Tag value 0 marks T1 and 1 marks T2, on both rstTag and rdTag. In linear mode only T1 strobes are issued.
- R10: In HDR mode, outSel=1 suppresses T2 reads and outSel=2 suppresses T1 reads. Values 0 and 3 issue both reads. Resets are never suppressed. In linear mode outSel is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameStart | input | 1 | One-cycle pulse that launches a frame |
| rowTick | input | 1 | One-cycle pulse per row period |
| hdrEn | input | 1 | 1 selects the dual-exposure mode |
| t2ByRows | input | 1 | 1 takes T2 from t2Rows, 0 from the ratio |
| ratioSel | input | 2 | Exposure ratio code, 0..3 for 4x..32x |
| outSel | input | 2 | Read output select: 0/3 both, 1 T1 only, 2 T2 only |
| rowFirst | input | ROW_W | First row of the window |
| rowLast | input | ROW_W | Last row of the window |
| t1Rows | input | INT_W | T1 integration in row periods |
| t2Rows | input | INT_W | T2 integration in row periods (row-count mode) |
| frameBusy | output | 1 | High while a frame is running |
| rstValid | output | 1 | Row reset strobe |
| rstRow | output | ROW_W | Row address of the reset |
| rstTag | output | 1 | Exposure tag of the reset |
| rdValid | output | 1 | Row read strobe |
| rdRow | output | ROW_W | Row address of the read |
| rdTag | output | 1 | Exposure tag of the read |

## Verification
Configuration is captured on the clock edge that samples frameStart. A row tick sampled at one edge gives T1 strobes visible after the next edge and T2 strobes visible after the edge that follows. The bench drives each tick for one cycle from a falling edge. It checks T1 strobes two falling edges later, T2 strobes and frameBusy three falling edges later, and the absence of any strobe at the fourth falling edge, where the next tick is launched. Expected rows are worked out per slot from the formulas in the requirements.

// File: rtl/shutter_seq_pkg.sv
package shutter_seq_pkg;
  // Strobes from the sequencing control to the datapath.
  typedef struct packed {
    logic latch;   // capture configuration, clear slot counter
    logic issueA;  // emit T1 reset/read for the current slot
    logic issueB;  // emit T2 reset/read, then advance the slot
  } seqCtl_t;

  localparam logic [1:0] SEL_T1_ONLY = 2'd1;
  localparam logic [1:0] SEL_T2_ONLY = 2'd2;
endpackage

// File: rtl/shutter_seq_ctrl.sv
module shutter_seq_ctrl
  import shutter_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    frameStart,
  input  logic    rowTick,
  input  logic    lastSlot,
  output seqCtl_t ctl,
  output logic    frameBusy
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_PHA, S_PHB} seqState_t;
  seqState_t state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE:  if (frameStart) state <= S_WAIT;
        S_WAIT:  if (rowTick) state <= S_PHA;
        S_PHA:   state <= S_PHB;
        default: state <= lastSlot ? S_IDLE : S_WAIT;
      endcase
    end
  end

  always_comb begin
    ctl.latch  = (state == S_IDLE) && frameStart;
    ctl.issueA = (state == S_PHA);
    ctl.issueB = (state == S_PHB);
  end

  assign frameBusy = (state != S_IDLE);
endmodule

// File: rtl/shutter_seq_dp.sv
module shutter_seq_dp
  import shutter_seq_pkg::*;
#(
  parameter int ROW_W = 11,
  parameter int INT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCtl_t          ctl,
  input  logic             hdrEn,
  input  logic             t2ByRows,
  input  logic [1:0]       ratioSel,
  input  logic [1:0]       outSel,
  input  logic [ROW_W-1:0] rowFirst,
  input  logic [ROW_W-1:0] rowLast,
  input  logic [INT_W-1:0] t1Rows,
  input  logic [INT_W-1:0] t2Rows,
  output logic             lastSlot,
  output logic             rstValid,
  output logic [ROW_W-1:0] rstRow,
  output logic             rstTag,
  output logic             rdValid,
  output logic [ROW_W-1:0] rdRow,
  output logic             rdTag
);
  localparam int SLOT_W = ((ROW_W > INT_W) ? ROW_W : INT_W) + 2;
  localparam logic [SLOT_W-1:0] ONE = SLOT_W'(1);

  // Configuration derived at frame start
  logic [SLOT_W-1:0] int1Next, int2Next, int2Ratio, int2Rows, shifted, t2Ext, nNext;
  logic [2:0]        shAmt;

  always_comb begin
    int1Next  = (t1Rows == '0) ? ONE : SLOT_W'(t1Rows);
    shAmt     = {1'b0, ratioSel} + 3'd2;
    shifted   = int1Next >> shAmt;
    int2Ratio = (shifted == '0) ? ONE : shifted;
    t2Ext     = (t2Rows == '0) ? ONE : SLOT_W'(t2Rows);
    int2Rows  = (t2Ext > int1Next) ? int1Next : t2Ext;
    int2Next  = t2ByRows ? int2Rows : int2Ratio;
    nNext     = (rowLast >= rowFirst)
                ? (SLOT_W'(rowLast) - SLOT_W'(rowFirst) + ONE) : ONE;
  end

  // Frame-stable copies
  logic [ROW_W-1:0]  firstL;
  logic [SLOT_W-1:0] nL, int1L, offL, slot;
  logic              hdrL;
  logic [1:0]        outSelL;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstL  <= '0;
      nL      <= ONE;
      int1L   <= ONE;
      offL    <= '0;
      hdrL    <= 1'b0;
      outSelL <= '0;
      slot    <= '0;
    end else if (ctl.latch) begin
      firstL  <= rowFirst;
      nL      <= nNext;
      int1L   <= int1Next;
      offL    <= int1Next - int2Next;
      hdrL    <= hdrEn;
      outSelL <= outSel;
      slot    <= '0;
    end else if (ctl.issueB) begin
      slot <= slot + ONE;
    end
  end

  // Per-slot due flags and row addresses
  logic [SLOT_W-1:0] rdIdx, t2Idx;
  logic              t1RstDue, t2RstDue, rdDue, emitT1Rd, emitT2Rd;
  logic [ROW_W-1:0]  t1RstRow, t2RstRow, rdRowNext;

  always_comb begin
    rdIdx     = slot - int1L;
    t2Idx     = slot - offL;
    t1RstDue  = (slot < nL);
    rdDue     = (slot >= int1L) && (rdIdx < nL);
    t2RstDue  = hdrL && (slot >= offL) && (t2Idx < nL);
    emitT1Rd  = !hdrL || (outSelL != SEL_T2_ONLY);
    emitT2Rd  = hdrL && (outSelL != SEL_T1_ONLY);
    t1RstRow  = firstL + ROW_W'(slot);
    t2RstRow  = firstL + ROW_W'(t2Idx);
    rdRowNext = firstL + ROW_W'(rdIdx);
    lastSlot  = (slot == (nL + int1L - ONE));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstValid <= 1'b0;
      rstRow   <= '0;
      rstTag   <= 1'b0;
      rdValid  <= 1'b0;
      rdRow    <= '0;
      rdTag    <= 1'b0;
    end else if (ctl.issueA) begin
      rstValid <= t1RstDue;
      rstRow   <= t1RstRow;
      rstTag   <= 1'b0;
      rdValid  <= rdDue && emitT1Rd;
      rdRow    <= rdRowNext;
      rdTag    <= 1'b0;
    end else if (ctl.issueB) begin
      rstValid <= t2RstDue;
      rstRow   <= t2RstRow;
      rstTag   <= 1'b1;
      rdValid  <= rdDue && emitT2Rd;
      rdRow    <= rdRowNext;
      rdTag    <= 1'b1;
    end else begin
      rstValid <= 1'b0;
      rdValid  <= 1'b0;
    end
  end
endmodule

// File: rtl/dual_exposure_shutter_seq.sv
module dual_exposure_shutter_seq
  import shutter_seq_pkg::*;
#(
  parameter int ROW_W = 11,
  parameter int INT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic             rowTick,
  input  logic             hdrEn,
  input  logic             t2ByRows,
  input  logic [1:0]       ratioSel,
  input  logic [1:0]       outSel,
  input  logic [ROW_W-1:0] rowFirst,
  input  logic [ROW_W-1:0] rowLast,
  input  logic [INT_W-1:0] t1Rows,
  input  logic [INT_W-1:0] t2Rows,
  output logic             frameBusy,
  output logic             rstValid,
  output logic [ROW_W-1:0] rstRow,
  output logic             rstTag,
  output logic             rdValid,
  output logic [ROW_W-1:0] rdRow,
  output logic             rdTag
);
  seqCtl_t ctl;
  logic    lastSlot;

  shutter_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .rowTick(rowTick),
    .lastSlot(lastSlot), .ctl(ctl), .frameBusy(frameBusy)
  );

  shutter_seq_dp #(.ROW_W(ROW_W), .INT_W(INT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .hdrEn(hdrEn), .t2ByRows(t2ByRows), .ratioSel(ratioSel), .outSel(outSel),
    .rowFirst(rowFirst), .rowLast(rowLast), .t1Rows(t1Rows), .t2Rows(t2Rows),
    .lastSlot(lastSlot),
    .rstValid(rstValid), .rstRow(rstRow), .rstTag(rstTag),
    .rdValid(rdValid), .rdRow(rdRow), .rdTag(rdTag)
  );
endmodule

// File: rtl/dual_exposure_shutter_seq_chk.sv
module dual_exposure_shutter_seq_chk #(
  parameter int ROW_W = 11
) (
  input logic             clk,
  input logic             rstN,
  input logic             rowTick,
  input logic             frameBusy,
  input logic             rstValid,
  input logic             rstTag,
  input logic             rdValid,
  input logic             rdTag,
  input logic [ROW_W-1:0] rdRow
);
  // R8: T1 read follows the row tick by two edges
  a_r8_t1_read_timing: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdTag) |-> $past(rowTick, 2));

  // R8: T2 read follows the row tick by three edges
  a_r8_t2_read_timing: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdTag) |-> $past(rowTick, 3));

  // R8: T1 reset follows the row tick by two edges
  a_r8_t1_reset_timing: assert property (@(posedge clk) disable iff (!rstN)
    (rstValid && !rstTag) |-> $past(rowTick, 2));

  // R5: a T2 read right after a T1 read addresses the same row
  a_r5_pair_same_row: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdTag && $past(rdValid && !rdTag)) |-> (rdRow == $past(rdRow)));

  // R2: no strobe once the frame has ended
  a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!frameBusy && !$past(frameBusy)) |-> !(rdValid || rstValid));
endmodule

bind dual_exposure_shutter_seq dual_exposure_shutter_seq_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rstN(rstN), .rowTick(rowTick), .frameBusy(frameBusy),
  .rstValid(rstValid), .rstTag(rstTag), .rdValid(rdValid), .rdTag(rdTag),
  .rdRow(rdRow)
);

// File: tb/dual_exposure_shutter_seq_tb.sv
`timescale 1ns/1ps
module dual_exposure_shutter_seq_tb;
  localparam int ROW_W = 11;
  localparam int INT_W = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 1'b0, rowTick = 1'b0, hdrEn = 1'b0, t2ByRows = 1'b0;
  logic [1:0] ratioSel = '0, outSel = '0;
  logic [ROW_W-1:0] rowFirst = '0, rowLast = '0;
  logic [INT_W-1:0] t1Rows = '0, t2Rows = '0;
  logic frameBusy, rstValid, rstTag, rdValid, rdTag;
  logic [ROW_W-1:0] rstRow, rdRow;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dual_exposure_shutter_seq #(.ROW_W(ROW_W), .INT_W(INT_W)) u_dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .rowTick(rowTick),
    .hdrEn(hdrEn), .t2ByRows(t2ByRows), .ratioSel(ratioSel), .outSel(outSel),
    .rowFirst(rowFirst), .rowLast(rowLast), .t1Rows(t1Rows), .t2Rows(t2Rows),
    .frameBusy(frameBusy), .rstValid(rstValid), .rstRow(rstRow), .rstTag(rstTag),
    .rdValid(rdValid), .rdRow(rdRow), .rdTag(rdTag)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // Runs one frame; expected values come from the requirement formulas.
  task automatic runFrame(input string rq, input int first, input int last,
                          input bit hdr, input bit byRows, input int ratio,
                          input int sel, input int t1, input int t2,
                          input bit perturb);
    int eN, eI1, eI2, d, t2c;
    bit selT1, selT2;
    eN  = (last >= first) ? last - first + 1 : 1;
    eI1 = (t1 == 0) ? 1 : t1;
    if (byRows) begin
      t2c = (t2 == 0) ? 1 : t2;
      eI2 = (t2c > eI1) ? eI1 : t2c;
    end else begin
      eI2 = eI1 >> (ratio + 2);
      if (eI2 == 0) eI2 = 1;
    end
    d = eI1 - eI2;
    selT1 = !hdr || (sel != 2);
    selT2 = hdr && (sel != 1);

    hdrEn = hdr; t2ByRows = byRows; ratioSel = 2'(ratio); outSel = 2'(sel);
    rowFirst = ROW_W'(first); rowLast = ROW_W'(last);
    t1Rows = INT_W'(t1); t2Rows = INT_W'(t2);
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    chk("R2", "busy after start", int'(frameBusy), 1);
    @(negedge clk);

    for (int s = 0; s < eN + eI1; s++) begin
      bit eR, eD;
      if (perturb && s == 2) begin
        // R2: mid-frame changes must not reach the running frame
        t1Rows = INT_W'(t1 + 5); rowLast = ROW_W'(last + 3);
        hdrEn = ~hdr; outSel = 2'd1; frameStart = 1'b1;
      end
      rowTick = 1'b1;
      @(negedge clk);
      rowTick = 1'b0; frameStart = 1'b0;
      @(negedge clk);
      // T1 phase
      eR = (s < eN);
      chk(rq, "T1 reset valid (R3)", int'(rstValid), int'(eR));
      if (eR) begin
        chk(rq, "T1 reset row (R3)", int'(rstRow), first + s);
        chk("R9", "T1 reset tag", int'(rstTag), 0);
      end
      eD = (s >= eI1) && (s - eI1 < eN) && selT1;
      chk(rq, "T1 read valid (R4)", int'(rdValid), int'(eD));
      if (eD) begin
        chk(rq, "T1 read row (R4)", int'(rdRow), first + s - eI1);
        chk("R9", "T1 read tag", int'(rdTag), 0);
      end
      @(negedge clk);
      // T2 phase
      eR = hdr && (s >= d) && (s - d < eN);
      chk(rq, "T2 reset valid (R5)", int'(rstValid), int'(eR));
      if (eR) begin
        chk(rq, "T2 reset row (R5)", int'(rstRow), first + s - d);
        chk("R9", "T2 reset tag", int'(rstTag), 1);
      end
      eD = hdr && (s >= eI1) && (s - eI1 < eN) && selT2;
      chk(rq, "T2 read valid (R5/R10)", int'(rdValid), int'(eD));
      if (eD) begin
        chk(rq, "T2 read row (R5)", int'(rdRow), first + s - eI1);
        chk("R9", "T2 read tag", int'(rdTag), 1);
      end
      chk("R3", "busy at slot end", int'(frameBusy), int'(s != eN + eI1 - 1));
      @(negedge clk);
      chk("R8", "no strobe outside phases", int'(rstValid || rdValid), 0);
    end
  endtask

  task automatic testReset();
    chk("R1", "busy in reset", int'(frameBusy), 0);
    chk("R1", "strobes in reset", int'(rstValid || rdValid), 0);
    chk("R1", "rows in reset", int'(rstRow) + int'(rdRow), 0);
    chk("R1", "tags in reset", int'(rstTag) + int'(rdTag), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "idle after reset", int'(frameBusy || rstValid || rdValid), 0);
  endtask

  task automatic testIgnoredTickWhenIdle();
    rowTick = 1'b1;
    @(negedge clk);
    rowTick = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R2", "tick while idle", int'(frameBusy || rstValid || rdValid), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testIgnoredTickWhenIdle();
    runFrame("R3", 5, 12, 0, 0, 0, 0, 3, 0, 0);        // linear
    runFrame("R10", 2, 6, 0, 0, 0, 2, 2, 0, 0);        // linear ignores outSel
    runFrame("R3", 9, 3, 0, 0, 0, 0, 0, 0, 0);         // inverted window, zero t1
    runFrame("R6", 10, 17, 1, 0, 0, 0, 8, 0, 0);       // 4x: I2=2
    runFrame("R6", 0, 5, 1, 0, 1, 3, 16, 0, 0);        // 8x: I2=2, sel 3
    runFrame("R6", 3, 7, 1, 0, 3, 0, 8, 0, 0);         // 32x: floor to 1
    runFrame("R7", 4, 9, 1, 1, 0, 0, 6, 3, 0);         // explicit rows
    runFrame("R7", 1, 4, 1, 1, 0, 0, 4, 9, 0);         // clamp to I1
    runFrame("R7", 1, 3, 1, 1, 0, 0, 3, 0, 0);         // zero -> 1
    runFrame("R10", 6, 11, 1, 0, 0, 1, 8, 0, 0);       // T1 reads only
    runFrame("R10", 6, 11, 1, 1, 0, 2, 5, 2, 0);       // T2 reads only
    runFrame("R2", 20, 27, 1, 0, 0, 0, 4, 0, 1);       // mid-frame changes
    repeat (4) @(negedge clk);
    chk("R2", "idle after frames", int'(frameBusy), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule